// File: doc/BRIEF.md
# GPIO Pin Interrupt Controller

This block watches a single general-purpose pin and raises an active-low interrupt line when a selected condition appears on it. The pin can cause an interrupt only when it is configured as an input and the interrupt is enabled. Software picks one of four trigger conditions: low level, high level, falling edge or rising edge.

A sticky status bit records that the pin raised the interrupt, and the interrupt line is its inverse. Software acknowledges the interrupt by reading the status with a one-cycle read strobe. The read clears the status only when the triggering condition has gone away. If a level trigger is still active at the time of the read, the status and the interrupt stay asserted. The pin is brought into the clock domain through a synchronizer, and edges are found by comparing consecutive synchronized samples.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, stat_o is 0, irq_no is 1, and the pin mode is 00 (not input). With no configuration written, no level on pin_i sets the status.
- R2: Pin-mode values 00, 10 and 11 never let the pin set the status. Only mode 01 (input) arms the pin.
- R3: With the enable bit at 0, the pin never sets the status. With the enable bit at 1 and mode 01, the pin is armed.
- R4: Trigger code 00 (low level) sets the status while the synchronized pin is 0.
- R5: Trigger code 01 (high level) sets the status while the synchronized pin is 1.
- R6: Trigger code 10 (falling edge) sets the status on a 1-to-0 transition of the synchronized pin, and never on a steady level.
- R7: Trigger code 11 (rising edge) sets the status on a 0-to-1 transition of the synchronized pin, and never on a steady level.
- R8: Once set, the status stays at 1 after the pin condition ends, until a read strobe or disarming clears it.
- R9: A read strobe clears the status on the next clock when the trigger condition is absent in the read cycle.
- R10: A read strobe while a level trigger is still active leaves the status and the interrupt asserted.
- R11: When a read strobe falls in the same cycle as a new edge event, the status stays at 1.
- R12: Clearing the enable bit, or writing a pin mode other than 01, drops a pending status to 0 one clock after the configuration register takes the new value.
- R13: irq_no is always the inverse of stat_o. With two synchronizer stages, a pin change that meets a trigger is seen on stat_o after the third rising clock edge following the change, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Asynchronous general-purpose pin |
| cfg_we_i | input | 1 | Write strobe that loads all three configuration fields |
| cfg_mode_i | input | 2 | Pin mode; 01 = input |
| cfg_en_i | input | 1 | Interrupt enable |
| cfg_trig_i | input | 2 | Trigger: 00 low, 01 high, 10 falling, 11 rising |
| stat_rd_i | input | 1 | Status read strobe (clear-on-read) |
| stat_o | output | 1 | Sticky interrupt status |
| irq_no | output | 1 | Interrupt output, active low |

## Verification
The clear-on-read strobe can land in the same cycle as a fresh trigger event. For level triggers this happens whenever the level is still held at the time of the read. For edges, the bench places the strobe in the exact cycle in which the second synchronized edge is detected. A read one cycle later, after the edge has passed, must clear the status. The outcome is judged only at stat_o and irq_no one edge after the strobe, against values derived from the trigger code and the pin level.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [1:0] {
    PM_OFF  = 2'b00,
    PM_IN   = 2'b01,
    PM_OUT0 = 2'b10,
    PM_OUT1 = 2'b11
  } pin_mode_e;

  typedef enum logic [1:0] {
    TRG_LOW  = 2'b00,
    TRG_HIGH = 2'b01,
    TRG_FALL = 2'b10,
    TRG_RISE = 2'b11
  } trig_e;

  typedef struct packed {
    pin_mode_e mode;
    logic      en;
    trig_e     trig;
  } cfg_t;

  localparam cfg_t CFG_RST = '{mode: PM_OFF, en: 1'b0, trig: TRG_LOW};

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= {STAGES{RST_VAL}};
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  lvl_i,
  input  trig_e trig_i,
  output logic  evt_o
);

  logic prev_q;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise = lvl_i & ~prev_q;
  assign fall = ~lvl_i & prev_q;

  always_comb begin
    unique case (trig_i)
      TRG_LOW:  evt_o = ~lvl_i;
      TRG_HIGH: evt_o = lvl_i;
      TRG_FALL: evt_o = fall;
      TRG_RISE: evt_o = rise;
      default:  evt_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic armed_i,
  input  logic evt_i,
  input  logic rd_i,
  output logic stat_o
);

  logic stat_q;

  // priority: disarm > new event > read clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       stat_q <= 1'b0;
    else if (!armed_i) stat_q <= 1'b0;
    else if (evt_i)    stat_q <= 1'b1;
    else if (rd_i)     stat_q <= 1'b0;
  end

  assign stat_o = stat_q;

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_i,
  input  logic       cfg_we_i,
  input  logic [1:0] cfg_mode_i,
  input  logic       cfg_en_i,
  input  logic [1:0] cfg_trig_i,
  input  logic       stat_rd_i,
  output logic       stat_o,
  output logic       irq_no
);

  cfg_t cfg_q;
  logic pin_s;
  logic evt;
  logic armed;
  logic stat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= CFG_RST;
    end else if (cfg_we_i) begin
      cfg_q.mode <= pin_mode_e'(cfg_mode_i);
      cfg_q.en   <= cfg_en_i;
      cfg_q.trig <= trig_e'(cfg_trig_i);
    end
  end

  assign armed = cfg_q.en & (cfg_q.mode == PM_IN);

  gpio_irq_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b0)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (pin_s)
  );

  gpio_irq_detect u_det (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (pin_s),
    .trig_i (cfg_q.trig),
    .evt_o  (evt)
  );

  gpio_irq_status u_stat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .armed_i (armed),
    .evt_i   (evt),
    .rd_i    (stat_rd_i),
    .stat_o  (stat)
  );

  assign stat_o = stat;
  assign irq_no = ~stat;

endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_i,
  input logic       en_i,
  input logic       armed_i,
  input logic       evt_i,
  input logic       rd_i,
  input logic       stat_i,
  input logic       irq_ni
);

  p_mode_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 2'b01) |=> !stat_i);

  p_en_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !stat_i);

  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_i && stat_i && !rd_i) |=> stat_i);

  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_i && stat_i && rd_i && !evt_i) |=> !stat_i);

  p_race_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_i && evt_i) |=> stat_i);

  p_out_inv_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ni == !stat_i);

endmodule

bind gpio_irq_ctrl gpio_irq_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .mode_i  (cfg_q.mode),
  .en_i    (cfg_q.en),
  .armed_i (armed),
  .evt_i   (evt),
  .rd_i    (stat_rd_i),
  .stat_i  (stat),
  .irq_ni  (irq_no)
);

// File: tb/tb_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_irq_ctrl;

  localparam real CLK_NS = 8.0;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic       cfg_en = 1'b0;
  logic [1:0] cfg_trig = 2'b00;
  logic       rd = 1'b0;
  logic       stat;
  logic       irq_n;

  int nchk = 0;
  int nbad = 0;

  always #(CLK_NS/2) clk = ~clk;

  gpio_irq_ctrl dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .pin_i      (pin),
    .cfg_we_i   (cfg_we),
    .cfg_mode_i (cfg_mode),
    .cfg_en_i   (cfg_en),
    .cfg_trig_i (cfg_trig),
    .stat_rd_i  (rd),
    .stat_o     (stat),
    .irq_no     (irq_n)
  );

  task automatic check(input string tag, input logic exp);
    nchk++;
    if (stat !== exp || irq_n !== ~exp) begin
      nbad++;
      $display("FAIL %s: stat=%b irq_n=%b expected stat=%b irq_n=%b",
               tag, stat, irq_n, exp, ~exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wcfg(input logic [1:0] m, input logic e, input logic [1:0] t);
    @(negedge clk);
    cfg_mode = m; cfg_en = e; cfg_trig = t; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_pulse();
    @(negedge clk);
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic set_pin(input logic v);
    @(negedge clk);
    pin = v;
  endtask

  initial begin
    #(CLK_NS * 200000);
    nchk++; nbad++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset state", 1'b0);
    set_pin(1'b1); edges(4);
    check("R1 default mode not input, pin high", 1'b0);
    set_pin(1'b0); edges(4);
    check("R1 default mode not input, pin low", 1'b0);

    for (int m = 0; m < 4; m++) begin
      for (int e = 0; e < 2; e++) begin
        for (int t = 0; t < 4; t++) begin
          automatic logic armed = (m == 1) && (e == 1);
          automatic string tg = (m != 1) ? "R2" : (e == 0) ? "R3" :
                                (t == 0) ? "R4" : (t == 1) ? "R5" :
                                (t == 2) ? "R6" : "R7";
          wcfg(2'(m), 1'(e), 2'(t));
          set_pin(1'b0); edges(4);
          rd_pulse();
          check($sformatf("%s/R10 low steady m%0d e%0d t%0d", tg, m, e, t),
                armed && t == 0);
          set_pin(1'b1); edges(2);
          check($sformatf("%s/R13 rise +2 edges m%0d e%0d t%0d", tg, m, e, t),
                armed && t == 0);
          edges(1);
          check($sformatf("%s/R13 rise +3 edges m%0d e%0d t%0d", tg, m, e, t),
                armed && t != 2);
          edges(3);
          check($sformatf("%s/R8 held high m%0d e%0d t%0d", tg, m, e, t),
                armed && t != 2);
          rd_pulse();
          check($sformatf("%s/R9/R10 read high m%0d e%0d t%0d", tg, m, e, t),
                armed && t == 1);
          set_pin(1'b0); edges(2);
          check($sformatf("%s/R13 fall +2 edges m%0d e%0d t%0d", tg, m, e, t),
                armed && t == 1);
          edges(1);
          check($sformatf("%s/R8 fall +3 edges m%0d e%0d t%0d", tg, m, e, t),
                armed && t != 3);
          rd_pulse();
          check($sformatf("%s/R9/R10 read low m%0d e%0d t%0d", tg, m, e, t),
                armed && t == 0);
        end
      end
    end

    // R12: disarm drops pending status
    wcfg(2'b01, 1'b1, 2'b00);
    set_pin(1'b0); edges(4);
    check("R12 armed low level pending", 1'b1);
    wcfg(2'b01, 1'b0, 2'b00);
    edges(1);
    check("R12 enable cleared", 1'b0);
    wcfg(2'b01, 1'b1, 2'b00);
    edges(1);
    check("R12 re-enabled low level", 1'b1);
    wcfg(2'b10, 1'b1, 2'b00);
    edges(1);
    check("R12 mode changed from input", 1'b0);
    wcfg(2'b01, 1'b1, 2'b01);
    edges(2);
    check("R12 high level, pin low, after rearm", 1'b0);

    // R11: read strobe in the same cycle as a new rising edge
    wcfg(2'b01, 1'b1, 2'b11);
    set_pin(1'b0); edges(4);
    rd_pulse();
    check("R11 setup cleared", 1'b0);
    set_pin(1'b1); edges(3);
    check("R7 first rise", 1'b1);
    set_pin(1'b0); edges(4);
    check("R8 held after pin fall", 1'b1);
    set_pin(1'b1);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    check("R11 read meets new edge", 1'b1);
    rd_pulse();
    check("R9 read after edge passed", 1'b0);

    // R11 for falling edge
    wcfg(2'b01, 1'b1, 2'b10);
    set_pin(1'b0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    check("R11 read meets falling edge", 1'b1);
    rd_pulse();
    check("R9 falling read clears", 1'b0);

    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

endmodule